// File: doc/BRIEF.md
# Transition-Edge Histogram Bit Aligner

This block finds where data edges fall inside the bit period of a serial lane, so that a good sampling phase can be chosen for that lane. Each lane delivers ten samples per clock cycle, taken at evenly spaced phase offsets. The phase clocks themselves are generated elsewhere; here they arrive as a parallel vector per lane. Two samples next to each other in phase order that disagree mark an edge between them. The block counts those edges per phase position on one selected lane over a fixed observation window.

Software starts a measurement by pulsing a launch input together with a lane number. A busy output goes high and stays high until the window has finished. While busy is low the ten bin counters can be read. Software then writes a tap number for the lane, and that tap picks which phase sample drives the lane's data output. In automatic mode the block picks the tap itself once the window ends. It chooses the phase opposite the busiest edge bin, which is the point of the eye farthest from the edges.

Top module: `hba_bit_aligner`

## Requirements
- R1: After reset, busy_o is 0, every bin counter reads 0 and every lane tap is 0.
- R2: A launch_i pulse while busy_o is 0 raises busy_o on the next cycle, clears all ten bins and latches launch_lane_i as the measured lane.
- R3: Lane l phase p is bit l*NUM_PHASES+p of phase_samples_i. In each window cycle, bin k (k from 1 to NUM_PHASES-1) adds one when phase k-1 and phase k of the measured lane differ. Bin 0 adds one when phase 0 differs from the last phase of the same lane in the previous cycle. Bin k is read at bin_count_o[k*CNT_W +: CNT_W].
- R4: Exactly WINDOW cycles are accumulated. busy_o then stays high one more cycle and falls, so it is high for WINDOW+1 cycles in total.
- R5: A bin that reaches 2^CNT_W-1 stays at that value and never wraps.
- R6: A launch_i pulse while busy_o is 1 is ignored. The lane, the window length and the counts are unaffected.
- R7: After busy_o falls, the bins keep their values until the next accepted launch, whatever the lane samples do.
- R8: In software mode (auto_mode_i=0), tap_wr_i with tap_wr_value_i below NUM_PHASES sets the tap of lane tap_wr_lane_i on the next cycle. A value of NUM_PHASES or above is ignored. Lane l's tap is lane_tap_o[l*TAP_W +: TAP_W].
- R9: In automatic mode (auto_mode_i=1), software tap writes are ignored. In the cycle busy_o falls, the measured lane's tap becomes (m + NUM_PHASES/2) mod NUM_PHASES, where m is the lowest-indexed bin holding the largest count.
- R10: lane_data_o[l] always equals phase sample lane_tap_o of lane l.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| launch_i | input | 1 | Start-measurement pulse |
| launch_lane_i | input | LANE_W | Lane to measure |
| auto_mode_i | input | 1 | 1 = automatic tap choice, 0 = software tap |
| phase_samples_i | input | NUM_LANES*NUM_PHASES | Phase samples of every lane |
| tap_wr_i | input | 1 | Software tap write strobe |
| tap_wr_lane_i | input | LANE_W | Lane whose tap is written |
| tap_wr_value_i | input | TAP_W | Tap value to write |
| busy_o | output | 1 | Measurement in progress |
| bin_count_o | output | NUM_PHASES*CNT_W | Edge histogram bins |
| lane_tap_o | output | NUM_LANES*TAP_W | Current tap of every lane |
| lane_data_o | output | NUM_LANES | Sample picked by each lane's tap |

## Verification
Several properties are checked in every cycle by assertions. A bin at its ceiling stays there, and bins hold still outside the window. A launch empties the bins and raises busy. The measured lane cannot change mid-measurement, the window ends on its last count, no tap leaves the legal range, and automatic mode keeps taps fixed except at the end of a window. Other behaviour can only be shown by the bench's scenarios: the exact bin values for a given sample pattern, including bin 0's dependence on the previous cycle, which bin wins a tie, and the resulting automatic tap. The same goes for ignoring a launch mid-window, rejecting out-of-range tap writes, and the data multiplexer following the tap.

// File: rtl/hba_pkg.sv
package hba_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_RESOLVE = 2'd2
    } hba_state_e;
endpackage

// File: rtl/hba_edge_detect.sv
module hba_edge_detect #(
    parameter int NUM_LANES  = 4,
    parameter int NUM_PHASES = 10,
    parameter int LANE_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_LANES*NUM_PHASES-1:0] samples_i,
    input  logic [LANE_W-1:0]               lane_sel_i,
    output logic [NUM_PHASES-1:0]           hits_o
);
    // last phase of every lane, kept each cycle so bin 0 is valid on any lane
    logic [NUM_LANES-1:0]  last_d, last_q;
    logic [NUM_PHASES-1:0] cur;

    always_comb begin
        cur = samples_i[int'(lane_sel_i)*NUM_PHASES +: NUM_PHASES];
        for (int l = 0; l < NUM_LANES; l++) begin
            last_d[l] = samples_i[l*NUM_PHASES + NUM_PHASES - 1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= last_d;
    end

    assign hits_o[0] = cur[0] ^ last_q[lane_sel_i];

    for (genvar k = 1; k < NUM_PHASES; k++) begin : g_pair
        assign hits_o[k] = cur[k-1] ^ cur[k];
    end
endmodule

// File: rtl/hba_bin_bank.sv
module hba_bin_bank #(
    parameter int NUM_PHASES = 10,
    parameter int CNT_W      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear_i,
    input  logic                        count_en_i,
    input  logic [NUM_PHASES-1:0]       hits_i,
    output logic [NUM_PHASES*CNT_W-1:0] counts_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [NUM_PHASES-1:0][CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        for (int k = 0; k < NUM_PHASES; k++) begin
            if (clear_i) begin
                cnt_d[k] = '0;
            end else if (count_en_i && hits_i[k] && cnt_q[k] != CNT_MAX) begin
                cnt_d[k] = cnt_q[k] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign counts_o = cnt_q;

    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_chk
        AST_BIN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (!clear_i && cnt_q[k] == CNT_MAX) |=> (cnt_q[k] == CNT_MAX)); // R5
    end

    AST_BIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !count_en_i) |=> $stable(counts_o)); // R7
    AST_BIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (counts_o == '0)); // R2
endmodule

// File: rtl/hba_tap_pick.sv
module hba_tap_pick #(
    parameter int NUM_PHASES = 10,
    parameter int CNT_W      = 8,
    parameter int TAP_W      = $clog2(NUM_PHASES)
) (
    input  logic [NUM_PHASES*CNT_W-1:0] counts_i,
    output logic [TAP_W-1:0]            tap_o
);
    logic [CNT_W-1:0] best_cnt;
    int               best_idx;

    always_comb begin
        best_idx = 0;
        best_cnt = counts_i[0 +: CNT_W];
        for (int k = 1; k < NUM_PHASES; k++) begin
            if (counts_i[k*CNT_W +: CNT_W] > best_cnt) begin
                best_cnt = counts_i[k*CNT_W +: CNT_W];
                best_idx = k;
            end
        end
        tap_o = TAP_W'((best_idx + NUM_PHASES/2) % NUM_PHASES);
    end
endmodule

// File: rtl/hba_bit_aligner.sv
module hba_bit_aligner
    import hba_pkg::*;
#(
    parameter int NUM_LANES  = 4,
    parameter int NUM_PHASES = 10,
    parameter int WINDOW     = 1024,
    parameter int CNT_W      = 8,
    parameter int LANE_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
    parameter int TAP_W      = $clog2(NUM_PHASES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            launch_i,
    input  logic [LANE_W-1:0]               launch_lane_i,
    input  logic                            auto_mode_i,
    input  logic [NUM_LANES*NUM_PHASES-1:0] phase_samples_i,
    input  logic                            tap_wr_i,
    input  logic [LANE_W-1:0]               tap_wr_lane_i,
    input  logic [TAP_W-1:0]                tap_wr_value_i,
    output logic                            busy_o,
    output logic [NUM_PHASES*CNT_W-1:0]     bin_count_o,
    output logic [NUM_LANES*TAP_W-1:0]      lane_tap_o,
    output logic [NUM_LANES-1:0]            lane_data_o
);
    localparam int              WIN_W   = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);
    localparam logic [TAP_W:0]  NP_EXT  = (TAP_W+1)'(NUM_PHASES);

    typedef struct packed {
        hba_state_e                      state;
        logic [LANE_W-1:0]               lane;
        logic [WIN_W-1:0]                win;
        logic [NUM_LANES-1:0][TAP_W-1:0] taps;
    } ctl_t;

    ctl_t                  ctl_d, ctl_q;
    logic                  clear;
    logic                  count_en;
    logic [NUM_PHASES-1:0] hits;
    logic [TAP_W-1:0]      auto_tap;

    hba_edge_detect #(
        .NUM_LANES (NUM_LANES),
        .NUM_PHASES(NUM_PHASES),
        .LANE_W    (LANE_W)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .samples_i (phase_samples_i),
        .lane_sel_i(ctl_q.lane),
        .hits_o    (hits)
    );

    hba_bin_bank #(
        .NUM_PHASES(NUM_PHASES),
        .CNT_W     (CNT_W)
    ) u_bins (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .count_en_i(count_en),
        .hits_i    (hits),
        .counts_o  (bin_count_o)
    );

    hba_tap_pick #(
        .NUM_PHASES(NUM_PHASES),
        .CNT_W     (CNT_W),
        .TAP_W     (TAP_W)
    ) u_pick (
        .counts_i(bin_count_o),
        .tap_o   (auto_tap)
    );

    always_comb begin
        ctl_d    = ctl_q;
        clear    = 1'b0;
        count_en = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (launch_i) begin
                    ctl_d.state = ST_MEASURE;
                    ctl_d.lane  = launch_lane_i;
                    ctl_d.win   = '0;
                    clear       = 1'b1;
                end
            end
            ST_MEASURE: begin
                count_en = 1'b1;
                if (ctl_q.win == WIN_LAST) ctl_d.state = ST_RESOLVE;
                else                       ctl_d.win   = ctl_q.win + 1'b1;
            end
            ST_RESOLVE: begin
                ctl_d.state = ST_IDLE;
                if (auto_mode_i) ctl_d.taps[ctl_q.lane] = auto_tap;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
        if (!auto_mode_i && tap_wr_i && ({1'b0, tap_wr_value_i} < NP_EXT)) begin
            ctl_d.taps[tap_wr_lane_i] = tap_wr_value_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign busy_o     = (ctl_q.state != ST_IDLE);
    assign lane_tap_o = ctl_q.taps;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [NUM_PHASES-1:0] lane_vec;
        assign lane_vec       = phase_samples_i[l*NUM_PHASES +: NUM_PHASES];
        assign lane_data_o[l] = lane_vec[ctl_q.taps[l]];

        AST_TAP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            ({1'b0, ctl_q.taps[l]} < NP_EXT)); // R8
    end

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && launch_i) |=> busy_o); // R2
    AST_LANE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(ctl_q.lane)); // R6
    AST_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_MEASURE && ctl_q.win == WIN_LAST) |=> (ctl_q.state == ST_RESOLVE)); // R4
    AST_AUTO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode_i && ctl_q.state != ST_RESOLVE) |=> $stable(lane_tap_o)); // R9
endmodule

// File: tb/hba_bit_aligner_tb.sv
module hba_bit_aligner_tb;
    localparam int NL = 4;
    localparam int NP = 10;
    localparam int W  = 40;
    localparam int CW = 5;
    localparam int LW = 2;
    localparam int TW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              launch = 1'b0;
    logic [LW-1:0]     launch_lane = '0;
    logic              auto_mode = 1'b0;
    logic [NL*NP-1:0]  samples = '0;
    logic              tap_wr = 1'b0;
    logic [LW-1:0]     tap_lane = '0;
    logic [TW-1:0]     tap_val = '0;
    logic              busy;
    logic [NP*CW-1:0]  counts;
    logic [NL*TW-1:0]  taps;
    logic [NL-1:0]     ldata;

    int errors = 0;
    int checks = 0;
    int model [NP];
    int exp_tap [NL];

    always #10 clk = ~clk;

    hba_bit_aligner #(
        .NUM_LANES(NL), .NUM_PHASES(NP), .WINDOW(W), .CNT_W(CW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .launch_i(launch), .launch_lane_i(launch_lane),
        .auto_mode_i(auto_mode), .phase_samples_i(samples), .tap_wr_i(tap_wr),
        .tap_wr_lane_i(tap_lane), .tap_wr_value_i(tap_val), .busy_o(busy),
        .bin_count_o(counts), .lane_tap_o(taps), .lane_data_o(ldata)
    );

    // {auto, lane[1:0], pattern_a[9:0], pattern_b[9:0]}
    localparam logic [22:0] VEC [5] = '{
        {1'b1, 2'd0, 10'b0000011111, 10'b0000011111},
        {1'b1, 2'd1, 10'b1100110011, 10'b0011001100},
        {1'b0, 2'd2, 10'b1010101010, 10'b0101010101},
        {1'b1, 2'd3, 10'b0000000001, 10'b1111111110},
        {1'b1, 2'd2, 10'b0111000000, 10'b0111000000}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_bins(input string req);
        for (int k = 0; k < NP; k++) begin
            chk(int'(counts[k*CW +: CW]) == model[k], req, int'(counts[k*CW +: CW]), model[k]);
        end
    endtask

    task automatic check_taps(input string req);
        for (int l = 0; l < NL; l++) begin
            chk(int'(taps[l*TW +: TW]) == exp_tap[l], req, int'(taps[l*TW +: TW]), exp_tap[l]);
        end
    endtask

    task automatic measure(input logic [1:0] lane, input logic [9:0] pa,
                           input logic [9:0] pb, input bit am);
        logic [9:0] cur;
        logic       prev;
        int         best;
        @(negedge clk);
        auto_mode = am;
        launch = 1'b1;
        launch_lane = lane;
        samples[lane*NP +: NP] = pb;
        prev = pb[9];
        for (int k = 0; k < NP; k++) model[k] = 0;
        @(negedge clk);
        launch = 1'b0;
        chk(busy == 1'b1, "R2 busy after launch", busy, 1);
        for (int i = 0; i < W; i++) begin
            cur = (i % 2 == 0) ? pa : pb;
            samples[lane*NP +: NP] = cur;
            if ((cur[0] ^ prev) && model[0] < CMAX) model[0]++;
            for (int k = 1; k < NP; k++) begin
                if ((cur[k-1] ^ cur[k]) && model[k] < CMAX) model[k]++;
            end
            prev = cur[9];
            @(negedge clk);
        end
        chk(busy == 1'b1, "R4 busy in last cycle", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R4 busy falls", busy, 0);
        check_bins("R3 R5 bin value");
        if (am) begin
            best = 0;
            for (int k = 1; k < NP; k++) if (model[k] > model[best]) best = k;
            exp_tap[lane] = (best + NP/2) % NP;
        end
        check_taps("R9 tap after window");
    endtask

    task automatic write_tap(input logic [1:0] lane, input logic [3:0] val);
        @(negedge clk);
        tap_wr = 1'b1; tap_lane = lane; tap_val = val;
        @(negedge clk);
        tap_wr = 1'b0;
    endtask

    initial begin
        for (int l = 0; l < NL; l++) exp_tap[l] = 0;
        for (int k = 0; k < NP; k++) model[k] = 0;
        samples = 40'h5_A3C9_1E77;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy reset", busy, 0);
        check_bins("R1 bins reset");
        check_taps("R1 taps reset");
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 5; v++) begin
            measure(VEC[v][21:20], VEC[v][19:10], VEC[v][9:0], VEC[v][22]);
        end

        // R7: bins hold after the window whatever the samples do
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            samples = samples ^ {NL*NP{1'b1}};
        end
        check_bins("R7 bins hold");

        // R6: launch while busy ignored
        auto_mode = 1'b0;
        @(negedge clk);
        samples[1*NP +: NP] = '0;
        samples[2*NP +: NP] = 10'b1010101010;
        launch = 1'b1; launch_lane = 2'd1;
        @(negedge clk);
        launch = 1'b0;
        repeat (4) @(negedge clk);
        launch = 1'b1; launch_lane = 2'd2;
        @(negedge clk);
        launch = 1'b0;
        for (int i = 0; i < W - 5; i++) begin
            samples[2*NP +: NP] = ~samples[2*NP +: NP];
            @(negedge clk);
        end
        chk(busy == 1'b1, "R6 window length unchanged", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R6 busy falls on time", busy, 0);
        for (int k = 0; k < NP; k++) model[k] = 0;
        check_bins("R6 counts of original lane");

        // R8 / R10: software tap writes and data mux
        auto_mode = 1'b0;
        samples[2*NP +: NP] = 10'b0010000000;
        write_tap(2'd2, 4'd7);
        exp_tap[2] = 7;
        check_taps("R8 software tap write");
        chk(ldata[2] == 1'b1, "R10 mux picks phase 7", ldata[2], 1);
        write_tap(2'd2, 4'd12);
        check_taps("R8 out-of-range tap ignored");
        write_tap(2'd2, 4'd3);
        exp_tap[2] = 3;
        chk(ldata[2] == 1'b0, "R10 mux picks phase 3", ldata[2], 0);
        samples[2*NP +: NP] = 10'b0000001000;
        #1;
        chk(ldata[2] == 1'b1, "R10 mux follows sample", ldata[2], 1);

        // R9: software writes ignored in automatic mode
        auto_mode = 1'b1;
        write_tap(2'd0, 4'd1);
        check_taps("R9 software write ignored in auto");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule